// File: doc/BRIEF.md
# Terminator-Flagged Serial Field Assembler

The block takes a serial stream in which every data bit travels with a companion end-of-field flag. It builds each variable-length field one bit per handshake beat, and it presents the finished field on a fixed-width parallel output. The field's true length and an overflow indication come with it. A field has no fixed width and no length header. It ends on the beat whose flag is 1.

Bits arrive most significant first, so the bit that carries the terminating flag is the least significant bit of the value. Any field longer than the output register keeps only its most recent `FIELD_W` bits and raises the overflow output. The input side is a valid/ready handshake that carries one pair per beat. The output side holds a completed field with `out_valid` until `out_ready` accepts it. While a field waits, the input side stalls, so no pair is lost.

Top module: `efa_top`

## Requirements
- R1: A pair (`in_data`, `in_last`) is consumed exactly on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 1 whenever no completed field is pending on the output.
- R2: A field completes on the beat whose `in_last` is 1, and `out_valid` is 1 from the following cycle on. A beat with `in_last` = 0 never completes a field.
- R3: Earlier bits are more significant. The terminating bit lands in `out_field[0]`, and all bits of `out_field` at positions equal to or above the field length are 0.
- R4: A field may be one bit long, when the first pair of a field has `in_last` = 1. It reports `out_len` = 1 and `out_field` = that bit.
- R5: `out_len` gives the number of bits in the field and saturates at 2^`LEN_W`-1 (65535 by default).
- R6: If a field's length exceeds `FIELD_W`, `out_field` holds the last `FIELD_W` bits received and `out_ovf` is 1. If the length is `FIELD_W` or less, `out_ovf` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_field`, `out_len` and `out_ovf` stay unchanged. A pair offered in that time is not consumed until the field is accepted.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1. Parsing starts with the first pair accepted, and any partly collected field is discarded.
- R9: `out_valid` returns to 0 in the cycle after an edge where `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | The block can take a pair |
| in_data | input | 1 | Data bit of the pair |
| in_last | input | 1 | End-of-field flag of the pair |
| out_valid | output | 1 | A completed field is presented |
| out_ready | input | 1 | The consumer takes the field |
| out_field | output | FIELD_W | Assembled field, terminating bit at bit 0 |
| out_len | output | LEN_W | Field length in bits, saturating |
| out_ovf | output | 1 | Field was longer than FIELD_W |

## Verification
A vector table drives the main path with single-bit fields of value 0 and 1, short fields whose upper bits are 1 and 0, a field exactly `FIELD_W` long, and fields one bit and several bits longer than `FIELD_W`. Together they separate the bit order, the zeroing of unused upper bits, and the boundary where overflow starts. Directed tests cover four more cases:
- A stalled output with a pair waiting, which exposes lost or duplicated pairs.
- A reset in the middle of a field, which exposes stale bits carried into the next field.
- A field long enough to reach the length counter's saturation point.
- Back-to-back fields, which expose state left over from one field to the next.

// File: rtl/efa_pkg.sv
package efa_pkg;
    localparam int EFA_FIELD_W = 32;
    localparam int EFA_LEN_W   = 16;
endpackage

// File: rtl/efa_accum.sv
module efa_accum #(
    parameter int FIELD_W = efa_pkg::EFA_FIELD_W,
    parameter int LEN_W   = efa_pkg::EFA_LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic               bit_i,
    input  logic               last_i,
    output logic               done_o,
    output logic [FIELD_W-1:0] field_o,
    output logic [LEN_W-1:0]   len_o,
    output logic               ovf_o
);
    localparam logic [LEN_W-1:0] LEN_MAX  = '1;
    localparam logic [LEN_W-1:0] W_AS_LEN = LEN_W'(FIELD_W);

    typedef struct packed {
        logic [FIELD_W-1:0] sh;
        logic [LEN_W-1:0]   cnt;
        logic               ovf;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [FIELD_W-1:0] shifted;
    logic [LEN_W-1:0]   cnt_inc;
    logic               ovf_now;

    always_comb begin
        shifted = {acc_q.sh[FIELD_W-2:0], bit_i};
        cnt_inc = (acc_q.cnt == LEN_MAX) ? acc_q.cnt : acc_q.cnt + 1'b1;
        ovf_now = acc_q.ovf | (acc_q.cnt >= W_AS_LEN);
        acc_d   = acc_q;
        if (take_i) begin
            if (last_i) begin
                acc_d = '0;
            end else begin
                acc_d.sh  = shifted;
                acc_d.cnt = cnt_inc;
                acc_d.ovf = ovf_now;
            end
        end
        done_o  = take_i & last_i;
        field_o = shifted;
        len_o   = cnt_inc;
        ovf_o   = ovf_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    AST_CLEAR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && last_i) |=> (acc_q.cnt == '0 && acc_q.sh == '0 && !acc_q.ovf)); // R8
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(acc_q)); // R1
endmodule

// File: rtl/efa_hold.sv
module efa_hold #(
    parameter int FIELD_W = efa_pkg::EFA_FIELD_W,
    parameter int LEN_W   = efa_pkg::EFA_LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               ovf_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [FIELD_W-1:0] field_o,
    output logic [LEN_W-1:0]   len_o,
    output logic               ovf_o
);
    typedef struct packed {
        logic               vld;
        logic [FIELD_W-1:0] field;
        logic [LEN_W-1:0]   len;
        logic               ovf;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (load_i) begin
            hd_d.vld   = 1'b1;
            hd_d.field = field_i;
            hd_d.len   = len_i;
            hd_d.ovf   = ovf_i;
        end else if (hd_q.vld && ready_i) begin
            hd_d.vld = 1'b0;
        end
        valid_o = hd_q.vld;
        field_o = hd_q.field;
        len_o   = hd_q.len;
        ovf_o   = hd_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    AST_NO_LOAD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !hd_q.vld); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_q.vld && !ready_i) |=> (hd_q.vld && $stable(hd_q.field) && $stable(hd_q.len) && $stable(hd_q.ovf))); // R7
endmodule

// File: rtl/efa_top.sv
module efa_top #(
    parameter int FIELD_W = efa_pkg::EFA_FIELD_W,
    parameter int LEN_W   = efa_pkg::EFA_LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FIELD_W-1:0] out_field,
    output logic [LEN_W-1:0]   out_len,
    output logic               out_ovf
);
    localparam logic [LEN_W-1:0] W_AS_LEN = LEN_W'(FIELD_W);

    logic               take;
    logic               done;
    logic [FIELD_W-1:0] asm_field;
    logic [LEN_W-1:0]   asm_len;
    logic               asm_ovf;

    always_comb begin
        in_ready = !out_valid;
        take     = in_valid && in_ready;
    end

    efa_accum #(.FIELD_W(FIELD_W), .LEN_W(LEN_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .bit_i   (in_data),
        .last_i  (in_last),
        .done_o  (done),
        .field_o (asm_field),
        .len_o   (asm_len),
        .ovf_o   (asm_ovf)
    );

    efa_hold #(.FIELD_W(FIELD_W), .LEN_W(LEN_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (done),
        .field_i (asm_field),
        .len_i   (asm_len),
        .ovf_i   (asm_ovf),
        .ready_i (out_ready),
        .valid_o (out_valid),
        .field_o (out_field),
        .len_o   (out_len),
        .ovf_o   (out_ovf)
    );

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ovf == (out_len > W_AS_LEN))); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ovf) |-> ((out_field >> out_len) == '0)); // R3
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid); // R9
    AST_END_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> out_valid); // R2
endmodule

// File: tb/efa_top_tb.sv
module efa_top_tb;
    localparam int W  = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_data = 1'b0;
    logic          in_last = 1'b0;
    logic          out_ready = 1'b0;
    logic          in_ready;
    logic          out_valid;
    logic [W-1:0]  out_field;
    logic [LW-1:0] out_len;
    logic          out_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    efa_top #(.FIELD_W(W), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_field(out_field), .out_len(out_len), .out_ovf(out_ovf)
    );

    // length (32 bits) then pattern (64 bits), sent from bit len-1 down to bit 0
    localparam logic [95:0] VECS [0:7] = '{
        {32'd1,  64'h1},                  // R4 single 1
        {32'd1,  64'h0},                  // R4 single 0
        {32'd5,  64'h16},                 // R3 short, top bit 1
        {32'd8,  64'h01},                 // R3 short, top bits 0
        {32'd32, 64'hDEADBEEF},           // R6 exactly W
        {32'd33, 64'h1_2345_6789},        // R6 one past W
        {32'd40, 64'hA5_C3C3_5A5A},       // R6 well past W
        {32'd16, 64'h8001}                // R2 back to back
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_pair(input logic d, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic finish_and_accept(input longint exp_f, input longint exp_l, input bit exp_o, input string tag);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check(out_valid == 1'b1, {tag, " R2 valid"}, longint'(out_valid), 1);
        check(out_field == exp_f[W-1:0], {tag, " R3 field"}, longint'(out_field), exp_f);
        check(out_len == exp_l[LW-1:0], {tag, " R5 len"}, longint'(out_len), exp_l);
        check(out_ovf == exp_o, {tag, " R6 ovf"}, longint'(out_ovf), longint'(exp_o));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1'b0, {tag, " R9 release"}, longint'(out_valid), 0);
    endtask

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [W-1:0] held_f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 reset valid", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R8 reset ready", longint'(in_ready), 1);

        for (int v = 0; v < 8; v++) begin
            int L;
            logic [63:0] p;
            longint ef;
            L = int'(VECS[v][95:64]);
            p = VECS[v][63:0];
            for (int i = L - 1; i >= 0; i--) put_pair(p[i], i == 0);
            if (L >= W) ef = longint'(p[W-1:0]);
            else        ef = longint'(p & ((64'h1 << L) - 1));
            finish_and_accept(ef, longint'(L), L > W, $sformatf("vec%0d", v));
        end

        // R7: output stalled, a pair waits at the input
        put_pair(1'b1, 1'b0); put_pair(1'b1, 1'b1);
        @(negedge clk);
        in_valid = 1'b1; in_data = 1'b1; in_last = 1'b0;
        held_f = out_field;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R7 ready low while full", longint'(in_ready), 0);
            check(out_field == held_f && out_len == 2, "R7 outputs stable", longint'(out_field), longint'(held_f));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(in_ready == 1'b1, "R1 ready after accept", longint'(in_ready), 1);
        @(posedge clk);
        put_pair(1'b0, 1'b1);
        finish_and_accept(64'h2, 2, 1'b0, "R7 waiting pair kept once");

        // R8: reset mid-field discards partial bits
        put_pair(1'b1, 1'b0); put_pair(1'b1, 1'b0); put_pair(1'b1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        put_pair(1'b0, 1'b1);
        finish_and_accept(64'h0, 1, 1'b0, "R8 partial discarded");

        // R5: length saturation on a very long field, data = beat index parity
        for (int k = 0; k < 65540; k++) put_pair(k[0], k == 65539);
        finish_and_accept(64'h55555555, 65535, 1'b1, "R5 saturate");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule